// File: doc/BRIEF.md
# HDLC Serial Frame Receiver with Residue Reporting

This block is the receive half of a bit-oriented HDLC link. It takes a recovered serial bit stream qualified by a one-cycle bit enable. It looks for flag octets, deletes the zeros that the transmitter inserted after runs of five ones, and checks the 16-bit frame check sequence. Payload bits are packed into bytes least significant bit first and placed in a small receive queue. A read strobe pops the queue. The head byte is always presented on the read data port.

A frame whose payload length is not a whole number of bytes is still delivered. Its final partial byte is pushed with the valid bits packed at the top. A residue flag and a mask register then tell software how many of those bits are real. The residue flag and the CRC error flag hold their end-of-frame values through idle flags. Both clear only once the following frame has clearly started. A sticky overrun flag records bytes that were lost to a full queue. A single interrupt line compares the queue fill level with a programmable threshold.

Top module: `hdlc_rx`

## Requirements
- R1: Each payload byte is assembled least significant bit first: the first payload bit received after the opening flag lands in bit 0. Bytes enter the queue in arrival order.
- R2: The octet 01111110 (sent left to right) delimits frames. Inside a frame, a 0 that follows five consecutive 1s is deleted. Runs of back-to-back flags between frames push nothing and change no status.
- R3: The last 16 bits before the closing flag form the FCS and are never queued. The check uses CRC-16 with the reflected polynomial 0x8408, processed LSB first and preset to 0xFFFF. At the closing flag, the CRC error flag is set to 1 when the register over payload plus FCS differs from 0xF0B8, and set to 0 otherwise.
- R4: Let r be the payload bit count modulo 8. At every closing flag, the residue flag becomes (r != 0) and the residue mask is rewritten with its top r bits set (0x00 when r = 0). When r != 0, the partial byte is pushed with its r bits in positions 7 down to 8-r and zeros below.
- R5: The residue flag and the CRC error flag keep their values through idle flags. Both clear on the enabled bit that delivers the 7th destuffed bit after a flag.
- R6: The error-clear strobe clears the overrun flag and leaves the CRC error flag unchanged.
- R7: The read data port shows the oldest queued byte. A read strobe removes it. The data-available output is 1 exactly when the queue is not empty. A read of an empty queue changes nothing.
- R8: The queue holds DEPTH bytes. A byte arriving while the queue is full is dropped and sets the overrun flag, which stays set until cleared.
- R9: The interrupt output is 1 exactly when the queue fill level is greater than the threshold input. With a threshold of 0 it therefore equals data-available.
- R10: Clock cycles with the bit enable low are ignored, whatever the serial data input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Qualifies one serial bit this cycle |
| bit_i | input | 1 | Recovered serial data |
| rd_en_i | input | 1 | Pops the head byte of the queue |
| err_clr_i | input | 1 | Clears the overrun flag |
| irq_thresh_i | input | $clog2(DEPTH+1) | Fill level that the queue must exceed to interrupt |
| rd_data_o | output | 8 | Head byte of the queue |
| rx_avail_o | output | 1 | Queue holds at least one byte |
| crc_err_o | output | 1 | Last frame failed the FCS check |
| resid_o | output | 1 | Last frame ended off a byte boundary |
| resid_code_o | output | 8 | Mask of valid bits in the last partial byte |
| overrun_o | output | 1 | Sticky: a byte was dropped on a full queue |
| irq_o | output | 1 | Fill level above threshold |

## Verification
The bench uses the default queue depth of 4. With that depth, a 40-bit payload overflows the queue by exactly one byte, and every frame of up to 32 payload bits fits and drains completely. Swept payload lengths of 8k through 8k+7 bits, for k from 1 to 3, reach every residue mask and every partial-byte layout. Random line gaps and corrupted FCS bits are mixed in. The threshold input is driven to 0 and 2, which exercises the interrupt both tracking data-available and lagging behind it.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam int          FLAG_TAIL  = 6;        // destuffed bits a flag leaves behind
  localparam int          FCS_BITS   = 16;
  localparam logic [15:0] CRC_POLY   = 16'h8408; // reflected x^16+x^12+x^5+1
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] n;
    n = {1'b0, c[15:1]};
    if (c[0] ^ b) n = n ^ CRC_POLY;
    return n;
  endfunction

  function automatic logic [7:0] top_mask(input logic [2:0] n);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (n != 3'd0) && (i >= 8 - int'(n));
    return m;
  endfunction

endpackage

// File: rtl/hdlc_rx_unstuff.sv
module hdlc_rx_unstuff (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic dat_vld,
  output logic dat_bit,
  output logic flag_hit,
  output logic abort_hit
);
  logic [2:0] ones_q, ones_d;
  logic       infr_q, infr_d;

  always_comb begin
    ones_d    = ones_q;
    infr_d    = infr_q;
    dat_vld   = 1'b0;
    flag_hit  = 1'b0;
    abort_hit = 1'b0;
    dat_bit   = bit_in;
    if (bit_en) begin
      if (bit_in) begin
        if (ones_q >= 3'd6) begin
          ones_d = 3'd7;
          if (infr_q && ones_q == 3'd6) begin
            abort_hit = 1'b1;
            infr_d    = 1'b0;
          end
        end else begin
          ones_d  = ones_q + 3'd1;
          dat_vld = infr_q && (ones_q < 3'd5);
        end
      end else begin
        ones_d = 3'd0;
        if (ones_q == 3'd6) begin
          flag_hit = 1'b1;
          infr_d   = 1'b1;
        end else if (ones_q < 3'd5) begin
          dat_vld = infr_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= 3'd0;
      infr_q <= 1'b0;
    end else if (bit_en) begin
      ones_q <= ones_d;
      infr_q <= infr_d;
    end
  end

  p_stuff_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !bit_in && ones_q == 3'd5) |-> !dat_vld && !flag_hit);

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dat_vld,
  input  logic       dat_bit,
  input  logic       flag_hit,
  input  logic       abort_hit,
  output logic       push,
  output logic [7:0] push_data,
  output logic       resid,
  output logic [7:0] resid_code,
  output logic       crc_err
);
  localparam int DLY = FLAG_TAIL + FCS_BITS;
  localparam int CW  = $clog2(DLY + 1);

  logic [DLY-1:0] dl_q, dl_d;
  logic [CW-1:0]  dcnt_q, dcnt_d;
  logic [15:0]    crc_q, crc_d;
  logic [7:0]     asm_q, asm_d;
  logic [2:0]     acnt_q, acnt_d;
  logic           res_d, cerr_d;
  logic [7:0]     code_d;
  logic           feed_crc, feed_pay, sof, eof;

  assign feed_crc = dat_vld && (dcnt_q >= CW'(FLAG_TAIL));
  assign feed_pay = dat_vld && (dcnt_q == CW'(DLY));
  assign sof      = dat_vld && (dcnt_q == CW'(FLAG_TAIL));
  assign eof      = flag_hit && (dcnt_q == CW'(DLY));

  always_comb begin
    dl_d      = dat_vld ? {dl_q[DLY-2:0], dat_bit} : dl_q;
    dcnt_d    = (dat_vld && dcnt_q != CW'(DLY)) ? dcnt_q + CW'(1) : dcnt_q;
    crc_d     = feed_crc ? crc_step(crc_q, dl_q[FLAG_TAIL-1]) : crc_q;
    asm_d     = feed_pay ? {dl_q[DLY-1], asm_q[7:1]} : asm_q;
    acnt_d    = feed_pay ? acnt_q + 3'd1 : acnt_q;
    push      = feed_pay && (acnt_q == 3'd7);
    push_data = asm_d;
    res_d     = resid;
    code_d    = resid_code;
    cerr_d    = crc_err;
    if (sof) begin
      res_d  = 1'b0;
      cerr_d = 1'b0;
    end
    if (eof) begin
      push      = (acnt_q != 3'd0);
      push_data = asm_q & top_mask(acnt_q);
      res_d     = (acnt_q != 3'd0);
      code_d    = top_mask(acnt_q);
      cerr_d    = (crc_q != CRC_GOOD);
    end
    if (flag_hit || abort_hit) begin
      dcnt_d = '0;
      crc_d  = CRC_PRESET;
      acnt_d = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q       <= '0;
      dcnt_q     <= '0;
      crc_q      <= CRC_PRESET;
      asm_q      <= '0;
      acnt_q     <= 3'd0;
      resid      <= 1'b0;
      resid_code <= '0;
      crc_err    <= 1'b0;
    end else begin
      dl_q       <= dl_d;
      dcnt_q     <= dcnt_d;
      crc_q      <= crc_d;
      asm_q      <= asm_d;
      acnt_q     <= acnt_d;
      resid      <= res_d;
      resid_code <= code_d;
      crc_err    <= cerr_d;
    end
  end

  p_resid_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resid |-> (resid_code[7] && !resid_code[0]));
  p_sof_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (!resid && !crc_err));
  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !eof) |=> ($stable(resid) && $stable(crc_err) && $stable(resid_code)));

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    wdata,
  input  logic          pop,
  input  logic          err_clr,
  output logic [7:0]    head,
  output logic [CW-1:0] count,
  output logic          overrun
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_d;
  logic          ovr_d, do_push, do_pop;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    do_pop  = pop && (count != '0);
    do_push = push && ((count != CW'(DEPTH)) || do_pop);
    wp_d    = do_push ? inc(wp_q) : wp_q;
    rp_d    = do_pop ? inc(rp_q) : rp_q;
    cnt_d   = count + CW'(do_push) - CW'(do_pop);
    ovr_d   = overrun;
    if (err_clr) ovr_d = 1'b0;
    if (push && !do_push) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      wp_q    <= wp_d;
      rp_q    <= rp_d;
      count   <= cnt_d;
      overrun <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign head = mem[rp_q];

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr) |=> overrun);
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !push) |=> (count == '0));

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en_i,
  input  logic          bit_i,
  input  logic          rd_en_i,
  input  logic          err_clr_i,
  input  logic [CW-1:0] irq_thresh_i,
  output logic [7:0]    rd_data_o,
  output logic          rx_avail_o,
  output logic          crc_err_o,
  output logic          resid_o,
  output logic [7:0]    resid_code_o,
  output logic          overrun_o,
  output logic          irq_o
);
  logic          dat_vld, dat_bit, flag_hit, abort_hit;
  logic          push;
  logic [7:0]    push_data;
  logic [CW-1:0] count;

  hdlc_rx_unstuff u_unstuff (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en_i), .bit_in(bit_i),
    .dat_vld(dat_vld), .dat_bit(dat_bit), .flag_hit(flag_hit), .abort_hit(abort_hit)
  );

  hdlc_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .dat_vld(dat_vld), .dat_bit(dat_bit),
    .flag_hit(flag_hit), .abort_hit(abort_hit), .push(push), .push_data(push_data),
    .resid(resid_o), .resid_code(resid_code_o), .crc_err(crc_err_o)
  );

  hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_data), .pop(rd_en_i),
    .err_clr(err_clr_i), .head(rd_data_o), .count(count), .overrun(overrun_o)
  );

  assign rx_avail_o = (count != '0);
  assign irq_o      = (count > irq_thresh_i);

  p_irq_zero_thresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_thresh_i == '0) |-> (irq_o == rx_avail_o));
  p_push_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rd_en_i) |=> rx_avail_o);
  p_errclr_keeps_crc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !dat_vld && !flag_hit) |=> $stable(crc_err_o));

endmodule

// File: tb/tb_hdlc_rx.sv
module tb_hdlc_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en_i = 1'b0, bit_i = 1'b0, rd_en_i = 1'b0, err_clr_i = 1'b0;
  logic [2:0] irq_thresh_i = 3'd0;
  logic [7:0] rd_data_o, resid_code_o;
  logic       rx_avail_o, crc_err_o, resid_o, overrun_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit pay[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdlc_rx #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en_i(bit_en_i), .bit_i(bit_i), .rd_en_i(rd_en_i),
    .err_clr_i(err_clr_i), .irq_thresh_i(irq_thresh_i), .rd_data_o(rd_data_o),
    .rx_avail_o(rx_avail_o), .crc_err_o(crc_err_o), .resid_o(resid_o),
    .resid_code_o(resid_code_o), .overrun_o(overrun_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input bit b);
    logic [15:0] n;
    n = c >> 1;
    if (c[0] != b) n = n ^ 16'h8408;
    return n;
  endfunction

  function automatic int ref_mask(input int r);
    int m = 0;
    for (int j = 0; j < r; j++) m |= 1 << (7 - j);
    return m;
  endfunction

  task automatic send_raw(input bit b);
    if ($urandom_range(0, 3) == 0) @(negedge clk);  // R10 gap, bit_i random while idle
    bit_i = b;
    bit_en_i = 1'b1;
    @(negedge clk);
    bit_en_i = 1'b0;
    bit_i = 1'($urandom);
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
  endtask

  task automatic send_frame(input bit corrupt, input bit probe, input bit pr, input bit pc);
    bit s[$];
    logic [15:0] c;
    int ones;
    c = 16'hFFFF;
    foreach (pay[i]) c = ref_crc(c, pay[i]);
    c = ~c;
    s = pay;
    for (int i = 0; i < 16; i++) s.push_back(c[i]);
    if (corrupt) s[pay.size()] = ~s[pay.size()];
    send_flag();
    ones = 0;
    for (int i = 0; i < s.size(); i++) begin
      send_raw(s[i]);
      if (probe && i == 5) begin
        chk("R5 resid held before 7th bit", int'(resid_o), int'(pr));
        chk("R5 crc_err held before 7th bit", int'(crc_err_o), int'(pc));
      end
      if (probe && i == 6) begin
        chk("R5 resid cleared at 7th bit", int'(resid_o), 0);
        chk("R5 crc_err cleared at 7th bit", int'(crc_err_o), 0);
      end
      if (s[i]) begin
        ones++;
        if (ones == 5) begin
          send_raw(1'b0);
          ones = 0;
        end
      end else ones = 0;
    end
    send_flag();
  endtask

  task automatic pop_byte(output logic [7:0] d);
    d = rd_data_o;
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic check_frame(input bit corrupt, input string tag);
    int n, r, nb;
    logic [7:0] d;
    int e;
    n  = pay.size();
    r  = n % 8;
    nb = n / 8 + ((r != 0) ? 1 : 0);
    chk("R4 resid flag", int'(resid_o), int'(r != 0));
    chk("R4 resid mask", int'(resid_code_o), ref_mask(r));
    chk("R3 crc_err", int'(crc_err_o), int'(corrupt));
    chk("R7 data available", int'(rx_avail_o), int'(nb > 0));
    if (nb > DEPTH) nb = DEPTH;
    for (int b = 0; b < nb; b++) begin
      e = 0;
      if (b < n / 8) begin
        for (int j = 0; j < 8; j++) e |= int'(pay[8 * b + j]) << j;
      end else begin
        for (int j = 0; j < r; j++) e |= int'(pay[8 * b + j]) << (8 - r + j);
      end
      pop_byte(d);
      chk(tag, int'(d), e);
    end
    chk("R7 queue drained", int'(rx_avail_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit cor;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset avail", int'(rx_avail_o), 0);
    chk("R9 reset irq", int'(irq_o), 0);
    chk("R4 reset resid", int'(resid_o), 0);
    chk("R4 reset mask", int'(resid_code_o), 0);
    chk("R3 reset crc_err", int'(crc_err_o), 0);
    chk("R8 reset overrun", int'(overrun_o), 0);

    // R7: read of an empty queue is harmless
    pop_byte(d);
    chk("R7 empty read avail", int'(rx_avail_o), 0);
    chk("R8 empty read overrun", int'(overrun_o), 0);

    // R2: stuffing inside payload (all ones)
    pay.delete();
    for (int i = 0; i < 16; i++) pay.push_back(1'b1);
    send_frame(1'b0, 1'b0, 1'b0, 1'b0);
    check_frame(1'b0, "R2 destuffed byte");

    // R1 R10: residue sweep with random data and line gaps
    for (int k = 1; k <= 3; k++) begin
      for (int r = 0; r < 8; r++) begin
        pay.delete();
        for (int i = 0; i < 8 * k + r; i++) pay.push_back(bit'($urandom));
        cor = ($urandom_range(0, 2) == 0);
        send_frame(cor, 1'b0, 1'b0, 1'b0);
        check_frame(cor, "R1 R10 queued byte");
      end
    end

    // R5: corrupted 8k+3 frame, hold through idle flags, clear on 7th bit
    pay.delete();
    for (int i = 0; i < 19; i++) pay.push_back(bit'($urandom));
    send_frame(1'b1, 1'b0, 1'b0, 1'b0);
    check_frame(1'b1, "R1 queued byte");
    send_flag();
    send_flag();
    chk("R2 R5 resid after idle flags", int'(resid_o), 1);
    chk("R5 crc_err after idle flags", int'(crc_err_o), 1);
    chk("R2 idle flags queue nothing", int'(rx_avail_o), 0);
    pay.delete();
    for (int i = 0; i < 7; i++) pay.push_back(1'b0);
    for (int i = 0; i < 9; i++) pay.push_back(bit'($urandom));
    send_frame(1'b0, 1'b1, 1'b1, 1'b1);
    check_frame(1'b0, "R5 queued byte");

    // R8 R6: overrun on 5 bytes, error clear keeps crc_err
    pay.delete();
    for (int i = 0; i < 40; i++) pay.push_back(bit'($urandom));
    send_frame(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 overrun set", int'(overrun_o), 1);
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
    chk("R6 overrun cleared", int'(overrun_o), 0);
    chk("R6 crc_err kept", int'(crc_err_o), 1);
    check_frame(1'b1, "R8 kept byte");

    // R9: threshold compare
    irq_thresh_i = 3'd2;
    pay.delete();
    for (int i = 0; i < 24; i++) pay.push_back(bit'($urandom));
    send_frame(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 irq 3>2", int'(irq_o), 1);
    pop_byte(d);
    chk("R9 irq 2>2", int'(irq_o), 0);
    irq_thresh_i = 3'd0;
    @(negedge clk);
    chk("R9 irq 2>0", int'(irq_o), 1);
    pop_byte(d);
    pop_byte(d);
    chk("R9 irq 0>0", int'(irq_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule